// File: doc/BRIEF.md
# Link Self-Test Controller with Error Counter

This block runs a built-in self-test session on the receive side of a serial link and keeps its result. Software writes one control byte. Bit 0 starts or stops the session. Bits [7:6] choose whether the receiver outputs stay live during the session. Bits [2:1] carry a test-clock code that is passed on to the remote transmitter. While the session runs, the block takes a per-cycle data-error strobe from the pattern checker and the receiver lock signal.

The block drives four things: a pass line, the output-enable gating, an idle request for the video output, and a readable error count. The count saturates one step below its maximum. The all-ones value is kept to mean that lock was missing at some point in the session. The clock code is latched once, when a session starts.

Top module: `link_bist_ctrl`

## Requirements
- R1: A write with bit 0 set arms the session and a write with bit 0 clear ends it. `bist_active` follows the stored bit 0 one clock after the write edge. `ctrl_rdata` returns the whole stored byte right after the write edge.
- R2: The error count and the lock-missing flag clear on the clock edge where a session starts. They keep their values while no session runs.
- R3: Each cycle in which `bist_active` and `data_err` are both high adds one to the count. The count stops at 0xFE. Strobes while `bist_active` is low are not counted.
- R4: If `rx_lock` is low in any cycle with `bist_active` high, `err_count` reads 0xFF from the next cycle until the next session start, whatever errors follow.
- R5: `pass` is high while `bist_active` is low. While `bist_active` is high, `pass` is low in exactly those cycles where `data_err` is high.
- R6: While `bist_active` is high, `out_en` is high only when stored bits [7:6] equal 2'b10. Codes 00, 01 and 11 drive it low. While `bist_active` is low, `out_en` is high.
- R7: `video_idle` is high when `bist_active` is high, bits [7:6] equal 2'b10 and `pgen_en` is low. Otherwise it is low.
- R8: Stored bits [2:1] are copied to `remote_clk_sel` on the session-start edge. `remote_clk_int` is high when that copy is non-zero (internal clock) and low for 00 (external clock). Writes to bits [2:1] during a session leave `remote_clk_sel` unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: [0] run, [2:1] clock code, [7:6] output mode |
| data_err | input | 1 | Per-cycle data-error strobe from the pattern checker |
| rx_lock | input | 1 | Receiver lock indication |
| pgen_en | input | 1 | Pattern generator drives the video output |
| ctrl_rdata | output | 8 | Stored control byte |
| bist_active | output | 1 | Session running |
| err_count | output | CNT_W | Error count; all ones means lock was missing |
| pass | output | 1 | Low in each errored cycle of a session |
| out_en | output | 1 | Receiver output enable |
| video_idle | output | 1 | Hold video output in low-power idle |
| remote_clk_sel | output | 2 | Latched test-clock code for the remote side |
| remote_clk_int | output | 1 | Latched code selects an internal clock |

## Verification
Four kinds of internal fault show up at the ports:
- A missed start clear shows as a non-zero `err_count` read two edges after the arming write.
- A wrong saturation bound shows as a wrapped or stuck count after a long burst of strobes.
- A lost lock-missing flag shows at once as a count other than 0xFF one cycle after `rx_lock` drops.
- A clock-code latch that follows writes shows as `remote_clk_sel` changing one edge after a mid-session write.

Because `pass` and the gating outputs are combinational from the active state, an error in that state appears in the same cycle.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;

  localparam int CTRL_W = 8;

  // output gating code that keeps receiver outputs live during a session
  localparam logic [1:0] OUT_MODE_LIVE = 2'b10;

  typedef struct packed {
    logic [1:0] out_mode;   // [7:6]
    logic [2:0] spare;      // [5:3]
    logic [1:0] clk_code;   // [2:1]
    logic       run;        // [0]
  } bist_ctrl_t;

endpackage

// File: rtl/link_bist_rst_sync.sv
module link_bist_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/link_bist_ctrl_reg.sv
module link_bist_ctrl_reg
  import link_bist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output bist_ctrl_t        ctrl_q,
  output logic              active_q,
  output logic              start,
  output logic [1:0]        clk_code_q
);
  bist_ctrl_t ctrl_d;
  logic       active_d;
  logic [1:0] clk_code_d;
  logic       ctrl_en;

  assign ctrl_en = wr;
  assign start   = ctrl_q.run & ~active_q;

  always_comb begin
    ctrl_d     = ctrl_q;
    if (ctrl_en) ctrl_d = bist_ctrl_t'(wdata);
    active_d   = ctrl_q.run;
    clk_code_d = clk_code_q;
    if (start) clk_code_d = ctrl_q.clk_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      active_q   <= 1'b0;
      clk_code_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      active_q <= active_d;
      if (start) clk_code_q <= clk_code_d;
    end
  end
endmodule

// File: rtl/link_bist_err_counter.sv
module link_bist_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             data_err,
  input  logic             rx_lock,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] SAT_MAX   = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] LOST_CODE = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lost_q, lost_d;
  logic             upd_en;

  assign upd_en = start | active;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (start) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (active) begin
      if (!rx_lock) lost_d = 1'b1;
      if (data_err && (cnt_q < SAT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign count = lost_q ? LOST_CODE : cnt_q;
endmodule

// File: rtl/link_bist_out_gate.sv
module link_bist_out_gate
  import link_bist_pkg::*;
(
  input  logic       active,
  input  logic [1:0] out_mode,
  input  logic       data_err,
  input  logic       pgen_en,
  output logic       pass,
  output logic       out_en,
  output logic       video_idle
);
  logic live;

  always_comb begin
    live       = (out_mode == OUT_MODE_LIVE);
    pass       = ~(active & data_err);
    out_en     = ~active | live;
    video_idle = active & live & ~pgen_en;
  end
endmodule

// File: rtl/link_bist_ctrl.sv
module link_bist_ctrl
  import link_bist_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              data_err,
  input  logic              rx_lock,
  input  logic              pgen_en,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic              bist_active,
  output logic [CNT_W-1:0]  err_count,
  output logic              pass,
  output logic              out_en,
  output logic              video_idle,
  output logic [1:0]        remote_clk_sel,
  output logic              remote_clk_int
);
  logic       srst_n;
  bist_ctrl_t ctrl_q;
  logic       active_q;
  logic       start_pulse;
  logic [1:0] clk_code_q;

  link_bist_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  link_bist_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr         (ctrl_wr),
    .wdata      (ctrl_wdata),
    .ctrl_q     (ctrl_q),
    .active_q   (active_q),
    .start      (start_pulse),
    .clk_code_q (clk_code_q)
  );

  link_bist_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start_pulse),
    .active   (active_q),
    .data_err (data_err),
    .rx_lock  (rx_lock),
    .count    (err_count)
  );

  link_bist_out_gate u_gate (
    .active     (active_q),
    .out_mode   (ctrl_q.out_mode),
    .data_err   (data_err),
    .pgen_en    (pgen_en),
    .pass       (pass),
    .out_en     (out_en),
    .video_idle (video_idle)
  );

  assign ctrl_rdata     = ctrl_q;
  assign bist_active    = active_q;
  assign remote_clk_sel = clk_code_q;
  assign remote_clk_int = |clk_code_q;
endmodule

// File: rtl/link_bist_ctrl_chk.sv
module link_bist_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic             start,
  input logic             bist_active,
  input logic             data_err,
  input logic             rx_lock,
  input logic [CNT_W-1:0] err_count,
  input logic             out_en,
  input logic [1:0]       remote_clk_sel
);
  localparam logic [CNT_W-1:0] SAT_MAX   = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] LOST_CODE = {CNT_W{1'b1}};

  // R1
  start_arms_chk: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> bist_active);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> (err_count == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!bist_active && !start) |=> $stable(err_count));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bist_active && rx_lock && data_err && (err_count < SAT_MAX))
      |=> (err_count == $past(err_count) + 1'b1));

  // R4
  lock_loss_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bist_active && !rx_lock) |=> (err_count == LOST_CODE));

  // R6
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !bist_active |-> out_en);

  // R8
  clk_code_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bist_active && $past(bist_active)) |-> $stable(remote_clk_sel));
endmodule

bind link_bist_ctrl link_bist_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .srst_n         (srst_n),
  .start          (start_pulse),
  .bist_active    (bist_active),
  .data_err       (data_err),
  .rx_lock        (rx_lock),
  .err_count      (err_count),
  .out_en         (out_en),
  .remote_clk_sel (remote_clk_sel)
);

// File: tb/tb_link_bist_ctrl.sv
`timescale 1ns/1ps
module tb_link_bist_ctrl;
  logic       clk;
  logic       rst_n;
  logic       ctrl_wr;
  logic [7:0] ctrl_wdata;
  logic       data_err;
  logic       rx_lock;
  logic       pgen_en;
  logic [7:0] ctrl_rdata;
  logic       bist_active;
  logic [7:0] err_count;
  logic       pass;
  logic       out_en;
  logic       video_idle;
  logic [1:0] remote_clk_sel;
  logic       remote_clk_int;

  int n_chk;
  int n_bad;

  link_bist_ctrl #(.CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .data_err(data_err), .rx_lock(rx_lock), .pgen_en(pgen_en),
    .ctrl_rdata(ctrl_rdata), .bist_active(bist_active), .err_count(err_count),
    .pass(pass), .out_en(out_en), .video_idle(video_idle),
    .remote_clk_sel(remote_clk_sel), .remote_clk_int(remote_clk_int)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // session vectors: {ctrl[39:32], errors[31:16], lock drop[15:8], expected count[7:0]}
  localparam int NVEC = 7;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h01, 16'd0,   8'd0, 8'h00},
    {8'h01, 16'd5,   8'd0, 8'h05},
    {8'h41, 16'd3,   8'd0, 8'h03},
    {8'h01, 16'd0,   8'd1, 8'hFF},
    {8'hC1, 16'd7,   8'd1, 8'hFF},
    {8'h01, 16'd254, 8'd0, 8'hFE},
    {8'h01, 16'd300, 8'd0, 8'hFE}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  task automatic errors(input int n);
    for (int i = 0; i < n; i++) begin
      data_err = 1'b1;
      @(negedge clk);
    end
    data_err = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0;
    data_err = 1'b0; rx_lock = 1'b1; pgen_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check("R1 reset active", bist_active, 0);
    check("R2 reset count", err_count, 0);
    check("R5 reset pass", pass, 1);
    check("R6 reset out_en", out_en, 1);
    check("R8 reset clk sel", remote_clk_sel, 0);

    // vector table of whole sessions
    for (int v = 0; v < NVEC; v++) begin
      write_ctrl(VEC[v][39:32]);
      @(negedge clk);
      errors(int'(VEC[v][31:16]));
      if (VEC[v][15:8] != 0) begin
        rx_lock = 1'b0;
        @(negedge clk);
        rx_lock = 1'b1;
      end
      errors(2'd0);
      write_ctrl(8'h00);
      @(negedge clk);
      check("R3/R4 session count", err_count, VEC[v][7:0]);
    end

    // R1 latency, readback, R8 capture, R6/R7 gating
    write_ctrl(8'h85);
    check("R1 ctrl readback", ctrl_rdata, 8'h85);
    check("R1 active latency", bist_active, 0);
    @(negedge clk);
    check("R1 active set", bist_active, 1);
    check("R2 start clear", err_count, 0);
    check("R8 clk sel latched", remote_clk_sel, 2);
    check("R8 internal clock", remote_clk_int, 1);
    check("R6 live out_en", out_en, 1);
    check("R7 video idle", video_idle, 1);
    pgen_en = 1'b1;
    #1 check("R7 pgen drives video", video_idle, 0);
    pgen_en = 1'b0;

    // R5 pass low exactly in the errored cycle
    @(negedge clk);
    data_err = 1'b1;
    #1 check("R5 pass low", pass, 0);
    @(negedge clk);
    data_err = 1'b0;
    #1 check("R5 pass back high", pass, 1);
    check("R3 single error", err_count, 1);

    // R8 clock code write during session ignored
    write_ctrl(8'h83);
    @(negedge clk);
    check("R8 mid-session write ignored", remote_clk_sel, 2);

    // stop, then strobes while idle
    write_ctrl(8'h80);
    @(negedge clk);
    check("R1 stopped", bist_active, 0);
    data_err = 1'b1;
    #1 check("R5 pass high idle", pass, 1);
    @(negedge clk);
    @(negedge clk);
    data_err = 1'b0;
    check("R3 idle strobes not counted", err_count, 1);
    check("R2 count held after stop", err_count, 1);

    // restart with new code and disabled outputs
    write_ctrl(8'h03);
    @(negedge clk);
    check("R8 new code on restart", remote_clk_sel, 1);
    check("R2 restart clears", err_count, 0);
    check("R6 mode 00 out_en", out_en, 0);
    write_ctrl(8'hC3);
    check("R6 mode 11 out_en", out_en, 0);
    write_ctrl(8'h43);
    check("R6 mode 01 out_en", out_en, 0);
    check("R7 no idle when gated", video_idle, 0);

    // R4 lock loss then recovery with errors
    rx_lock = 1'b0;
    @(negedge clk);
    rx_lock = 1'b1;
    check("R4 lock loss flag", err_count, 8'hFF);
    errors(3);
    check("R4 flag sticks over errors", err_count, 8'hFF);
    write_ctrl(8'h00);
    @(negedge clk);
    check("R4 flag held after stop", err_count, 8'hFF);
    write_ctrl(8'h01);
    @(negedge clk);
    check("R2 flag cleared on start", err_count, 0);
    check("R8 external clock", remote_clk_int, 0);
    write_ctrl(8'h00);
    @(negedge clk);

    summary();
  end
endmodule